// File: doc/BRIEF.md
# Conversion Mode Sequencer

This block sequences the conversions of a delta-sigma converter. Decoded command strobes (start/sync, power-down, reset) and a few configuration bits set the pace. In single-shot mode a start runs exactly one conversion. The block then falls back into its low-power state and the result is flagged as ready. In continuous mode a new conversion begins on the clock edge where the previous one completes, so the ready flag always refers to the newest finished result. All durations are counted in ticks of the converter clock, which reach the block as a clock-enable pulse.

The first continuous conversion after a start is longer than the ones that follow, because the filter must fill, and its length depends on the speed mode. Later conversions, and every single-shot conversion, take the length given on the `conv_len` input. When the internal oscillator is in use, a start that leaves the low-power state first waits out a wake-up interval whose length also depends on the speed mode.

The block also drives two side effects. The low-side bridge switch closes on a start and opens on power-down. The excitation-current enable turns on at a start when a nonzero current code is set, and turns off on power-down. Both stay active through the low-power gap between single-shot conversions.

Top module: `conv_sequencer`

## Requirements
- R1: After a hardware reset or a reset command, `low_pwr` is 1, `drdy_n` is 1, `sw_on` is 0 and `idac_on` is 0 on the next clock edge.
- R2: In single-shot mode (`cfg_cont`=0) with the external clock, `drdy_n` falls on the edge that registers the `conv_len`-th tick after the edge that accepts the start. `low_pwr` returns to 1 on that same edge.
- R3: In continuous mode (`cfg_cont`=1) the first conversion lasts FIRST_NORM ticks (`cfg_turbo`=0) or FIRST_TURBO ticks (`cfg_turbo`=1). Each later conversion lasts `conv_len` ticks and follows without a gap, and `low_pwr` stays 0.
- R4: With `use_int_osc`=1, a start accepted in the low-power state first waits WAKE_NORM or WAKE_TURBO ticks, chosen by `cfg_turbo`, and then runs the conversion.
- R5: A start accepted while a conversion is running restarts the tick count from zero, and no result is flagged for the aborted conversion.
- R6: `drdy_n` returns to 1 on the edge after `data_rd` or an accepted start.
- R7: With `cfg_psw`=1 an accepted start sets `sw_on`. `sw_on` stays 1 through the low-power state after a single-shot conversion and clears on power-down.
- R8: `cfg_psw`=0 forces `sw_on` to 0 in the same cycle. The switch stays open after `cfg_psw` returns to 1, until the next start.
- R9: An accepted start with a nonzero `cfg_idac` sets `idac_on`, which stays 1 between single-shot conversions and clears on power-down. With `cfg_idac`=0, `idac_on` stays 0.
- R10: Power-down aborts any conversion. `low_pwr` is 1 on the next edge and no result is flagged.
- R11: Reset takes priority over power-down, and power-down takes priority over start, when they arrive in the same cycle.
- R12: The tick count advances only on cycles where `tclk_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tclk_tick | input | 1 | Converter clock tick enable |
| cmd_start | input | 1 | Start/sync command strobe |
| cmd_pwrdn | input | 1 | Power-down command strobe |
| cmd_reset | input | 1 | Reset command strobe |
| cfg_cont | input | 1 | 1 = continuous, 0 = single-shot |
| cfg_turbo | input | 1 | 1 = turbo speed, 0 = normal |
| cfg_psw | input | 1 | Bridge switch allowed |
| cfg_idac | input | IDAC_W | Excitation current code, 0 = off |
| use_int_osc | input | 1 | Internal oscillator in use (wake-up delay) |
| conv_len | input | LEN_W | Conversion length in ticks |
| data_rd | input | 1 | Result read strobe |
| drdy_n | output | 1 | Data ready, active low |
| sw_on | output | 1 | Low-side bridge switch closed |
| idac_on | output | 1 | Excitation current sources enabled |
| low_pwr | output | 1 | Block in its low-power state |

## Verification
The bench aims at the latency corners. It checks the long first continuous conversion against the short ones that follow, in both speed modes, and it checks the wake-up delay that is added only when leaving low power on the internal oscillator. A design that used one length for every conversion, or that applied the wake-up delay on every conversion, would flag results at the wrong cycle, and the scoreboard compares each falling edge of `drdy_n` with the cycle it predicts. A second start issued mid-conversion catches a counter that does not restart. Simultaneous strobes catch a wrong command priority. Toggling `cfg_psw` catches a switch that reopens by itself. Idle phases between conversions catch switch or current enables that follow the conversion state instead of the commands.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_SLEEP = 2'd0,
    SEQ_WAKE  = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic rst;
    logic pd;
    logic go;
  } seq_cmd_t;

  // Reset beats power-down, power-down beats start.
  function automatic seq_cmd_t seq_decode(input logic r, input logic p, input logic s);
    seq_cmd_t c;
    c.rst = r;
    c.pd  = p & ~r;
    c.go  = s & ~p & ~r;
    return c;
  endfunction

endpackage

// File: rtl/conv_tick_ctr.sv
module conv_tick_ctr #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [LEN_W-1:0] target,
  output logic             hit
);
  logic [LEN_W-1:0] cnt_q, cnt_d, last;

  always_comb begin
    last = (target == '0) ? '0 : target - 1'b1;
    hit  = tick & (cnt_q == last);
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/conv_len_mux.sv
module conv_len_mux
  import conv_seq_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int FIRST_NORM  = 210,
  parameter int FIRST_TURBO = 114,
  parameter int WAKE_NORM   = 205,
  parameter int WAKE_TURBO  = 103
) (
  input  seq_state_t       state,
  input  logic             cont,
  input  logic             turbo,
  input  logic             first,
  input  logic [LEN_W-1:0] conv_len,
  output logic [LEN_W-1:0] target
);
  localparam logic [LEN_W-1:0] FN = LEN_W'(FIRST_NORM);
  localparam logic [LEN_W-1:0] FT = LEN_W'(FIRST_TURBO);
  localparam logic [LEN_W-1:0] WN = LEN_W'(WAKE_NORM);
  localparam logic [LEN_W-1:0] WT = LEN_W'(WAKE_TURBO);

  always_comb begin
    if (state == SEQ_WAKE)   target = turbo ? WT : WN;
    else if (cont && first)  target = turbo ? FT : FN;
    else                     target = conv_len;
  end
endmodule

// File: rtl/conv_fsm.sv
module conv_fsm
  import conv_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_cmd_t   cmd,
  input  logic       cont,
  input  logic       int_osc,
  input  logic       hit,
  output seq_state_t state,
  output logic       first,
  output logic       conv_done,
  output logic       clr
);
  seq_state_t st_q, st_d;
  logic       first_q, first_d, wake_done;

  always_comb begin
    st_d      = st_q;
    conv_done = 1'b0;
    wake_done = 1'b0;
    unique case (st_q)
      SEQ_SLEEP: if (cmd.go) st_d = int_osc ? SEQ_WAKE : SEQ_RUN;
      SEQ_WAKE:  if (!cmd.go && hit) begin
                   wake_done = 1'b1;
                   st_d      = SEQ_RUN;
                 end
      SEQ_RUN:   if (!cmd.go && hit) begin
                   conv_done = 1'b1;
                   st_d      = cont ? SEQ_RUN : SEQ_SLEEP;
                 end
      default:   st_d = SEQ_SLEEP;
    endcase
    if (cmd.rst || cmd.pd) begin
      st_d      = SEQ_SLEEP;
      conv_done = 1'b0;
      wake_done = 1'b0;
    end

    first_d = first_q;
    if (cmd.rst || cmd.pd) first_d = 1'b0;
    else if (cmd.go)       first_d = 1'b1;
    else if (conv_done)    first_d = 1'b0;

    clr = cmd.go | cmd.rst | cmd.pd | wake_done | conv_done | (st_q == SEQ_SLEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_SLEEP;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      first_q <= first_d;
    end
  end

  assign state = st_q;
  assign first = first_q;
endmodule

// File: rtl/conv_side_ctl.sv
module conv_side_ctl
  import conv_seq_pkg::*;
#(
  parameter int IDAC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_cmd_t          cmd,
  input  logic              conv_done,
  input  logic              data_rd,
  input  logic              psw,
  input  logic [IDAC_W-1:0] idac_code,
  output logic              drdy_n,
  output logic              sw_on,
  output logic              idac_on
);
  logic drdy_q, drdy_d, sw_q, sw_d, idac_q, idac_d, code_nz;

  assign code_nz = |idac_code;

  always_comb begin
    drdy_d = drdy_q;
    if (cmd.rst)                 drdy_d = 1'b1;
    else if (conv_done)          drdy_d = 1'b0;
    else if (cmd.go || data_rd)  drdy_d = 1'b1;

    sw_d = sw_q;
    if (cmd.rst || cmd.pd) sw_d = 1'b0;
    else if (!psw)         sw_d = 1'b0;
    else if (cmd.go)       sw_d = 1'b1;

    idac_d = idac_q;
    if (cmd.rst || cmd.pd)      idac_d = 1'b0;
    else if (!code_nz)          idac_d = 1'b0;
    else if (cmd.go)            idac_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drdy_q <= 1'b1;
      sw_q   <= 1'b0;
      idac_q <= 1'b0;
    end else begin
      drdy_q <= drdy_d;
      sw_q   <= sw_d;
      idac_q <= idac_d;
    end
  end

  assign drdy_n  = drdy_q;
  assign sw_on   = sw_q & psw;
  assign idac_on = idac_q & code_nz;
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int IDAC_W      = 3,
  parameter int FIRST_NORM  = 210,
  parameter int FIRST_TURBO = 114,
  parameter int WAKE_NORM   = 205,
  parameter int WAKE_TURBO  = 103
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tclk_tick,
  input  logic              cmd_start,
  input  logic              cmd_pwrdn,
  input  logic              cmd_reset,
  input  logic              cfg_cont,
  input  logic              cfg_turbo,
  input  logic              cfg_psw,
  input  logic [IDAC_W-1:0] cfg_idac,
  input  logic              use_int_osc,
  input  logic [LEN_W-1:0]  conv_len,
  input  logic              data_rd,
  output logic              drdy_n,
  output logic              sw_on,
  output logic              idac_on,
  output logic              low_pwr
);
  seq_cmd_t         cmd;
  seq_state_t       state;
  logic             first, conv_done, clr, hit;
  logic [LEN_W-1:0] target;

  assign cmd = seq_decode(cmd_reset, cmd_pwrdn, cmd_start);

  conv_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .cont(cfg_cont), .int_osc(use_int_osc),
    .hit(hit), .state(state), .first(first), .conv_done(conv_done), .clr(clr)
  );

  conv_len_mux #(
    .LEN_W(LEN_W), .FIRST_NORM(FIRST_NORM), .FIRST_TURBO(FIRST_TURBO),
    .WAKE_NORM(WAKE_NORM), .WAKE_TURBO(WAKE_TURBO)
  ) u_len (
    .state(state), .cont(cfg_cont), .turbo(cfg_turbo), .first(first),
    .conv_len(conv_len), .target(target)
  );

  conv_tick_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tclk_tick), .target(target), .hit(hit)
  );

  conv_side_ctl #(.IDAC_W(IDAC_W)) u_side (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .conv_done(conv_done), .data_rd(data_rd),
    .psw(cfg_psw), .idac_code(cfg_idac), .drdy_n(drdy_n), .sw_on(sw_on), .idac_on(idac_on)
  );

  assign low_pwr = (state == SEQ_SLEEP);
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_start,
  input logic cmd_pwrdn,
  input logic cmd_reset,
  input logic cfg_cont,
  input logic drdy_n,
  input logic sw_on,
  input logic idac_on,
  input logic low_pwr
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (low_pwr && drdy_n && !sw_on && !idac_on)); // R1
  AST_SINGLE_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(drdy_n) && !$past(cfg_cont)) |-> low_pwr); // R2
  AST_READY_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> !$past(low_pwr)); // R2
  AST_CONT_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(drdy_n) && $past(cfg_cont)) |-> !low_pwr); // R3
  AST_START_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !cmd_pwrdn && !cmd_reset) |=> (drdy_n && !low_pwr)); // R6
  AST_SWITCH_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_on) |-> $past(cmd_start)); // R7
  AST_CURRENT_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idac_on) |-> $past(cmd_start)); // R9
  AST_PWRDN_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pwrdn && !cmd_reset) |=> (low_pwr && !sw_on && !idac_on)); // R10
endmodule

bind conv_sequencer conv_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_pwrdn(cmd_pwrdn),
  .cmd_reset(cmd_reset), .cfg_cont(cfg_cont), .drdy_n(drdy_n), .sw_on(sw_on),
  .idac_on(idac_on), .low_pwr(low_pwr)
);

// File: tb/conv_sequencer_test.sv
module conv_sequencer_test;
  localparam int FN = 210, FT = 114, WN = 205, WT = 103, LEN = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0, cmd_pwrdn = 1'b0, cmd_reset = 1'b0;
  logic cfg_cont = 1'b0, cfg_turbo = 1'b0, cfg_psw = 1'b0, use_int_osc = 1'b0;
  logic [2:0] cfg_idac = 3'd0;
  logic [15:0] conv_len = 16'(LEN);
  logic rd_man = 1'b0, rd_auto = 1'b0, auto_read = 1'b0, half_tick = 1'b0;
  logic data_rd, tclk_tick, drdy_n, sw_on, idac_on, low_pwr, drdy_prev;
  int unsigned cyc = 0, tick_base = 0;
  int total = 0, bad = 0;
  bit finished = 1'b0;
  int unsigned exp_q[$];

  assign data_rd   = rd_man | rd_auto;
  assign tclk_tick = half_tick ? 1'((cyc - tick_base) & 1) : 1'b1;

  conv_sequencer #(.FIRST_NORM(FN), .FIRST_TURBO(FT), .WAKE_NORM(WN), .WAKE_TURBO(WT)) uut (
    .clk(clk), .rst_n(rst_n), .tclk_tick(tclk_tick), .cmd_start(cmd_start),
    .cmd_pwrdn(cmd_pwrdn), .cmd_reset(cmd_reset), .cfg_cont(cfg_cont),
    .cfg_turbo(cfg_turbo), .cfg_psw(cfg_psw), .cfg_idac(cfg_idac),
    .use_int_osc(use_int_osc), .conv_len(conv_len), .data_rd(data_rd),
    .drdy_n(drdy_n), .sw_on(sw_on), .idac_on(idac_on), .low_pwr(low_pwr)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Scoreboard monitor: each falling edge of drdy_n must match the next expected cycle.
  always @(negedge clk) begin
    rd_auto <= 1'b0;
    if (rst_n && drdy_prev && !drdy_n) begin
      if (exp_q.size() == 0) check(1'b0, "R2/R5/R10 unexpected ready", int'(cyc), -1);
      else begin
        automatic int unsigned e = exp_q.pop_front();
        check(cyc == e, "R2/R3/R4/R12 ready cycle", int'(cyc), int'(e));
      end
      if (auto_read) rd_auto <= 1'b1;
    end
    drdy_prev <= drdy_n;
  end

  // Driver: issue a start and push the predicted ready cycles.
  task automatic start_conv(input int lat, input int extra, input int step);
    @(negedge clk);
    cmd_start = 1'b1;
    tick_base = cyc;
    if (lat > 0) begin
      exp_q.push_back(cyc + 1 + lat);
      for (int k = 1; k <= extra; k++) exp_q.push_back(cyc + 1 + lat + k * step);
    end
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic pulse_pd();
    @(negedge clk); cmd_pwrdn = 1'b1;
    @(negedge clk); cmd_pwrdn = 1'b0;
  endtask

  task automatic pulse_read();
    @(negedge clk); rd_man = 1'b1;
    @(negedge clk); rd_man = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(input string req);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    drdy_prev = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check(low_pwr && drdy_n && !sw_on && !idac_on, "R1 reset state",
          {low_pwr, drdy_n, sw_on, idac_on}, 4'b1100);

    // R2 single shot, R7/R9 side effects persist in low power
    cfg_psw = 1'b1; cfg_idac = 3'd3;
    start_conv(LEN, 0, 0);
    idle(LEN + 5);
    drained("R2 single-shot done");
    check(low_pwr == 1'b1, "R2 back to low power", low_pwr, 1);
    check(sw_on == 1'b1, "R7 switch held closed", sw_on, 1);
    check(idac_on == 1'b1, "R9 current held on", idac_on, 1);
    pulse_read();
    @(negedge clk);
    check(drdy_n == 1'b1, "R6 read clears ready", drdy_n, 1);

    // R3 continuous normal and turbo
    cfg_cont = 1'b1; auto_read = 1'b1;
    start_conv(FN, 2, LEN);
    idle(FN + 2 * LEN + 5);
    check(low_pwr == 1'b0, "R3 continuous stays active", low_pwr, 0);
    pulse_pd();
    check(low_pwr && !sw_on && !idac_on, "R10 power-down state", {low_pwr, sw_on, idac_on}, 3'b100);
    drained("R3 continuous normal");
    cfg_turbo = 1'b1;
    start_conv(FT, 1, LEN);
    idle(FT + LEN + 5);
    pulse_pd();
    drained("R3 continuous turbo");
    cfg_cont = 1'b0; auto_read = 1'b0;
    pulse_read();

    // R4 wake-up delay with internal oscillator
    use_int_osc = 1'b1; cfg_turbo = 1'b0;
    start_conv(WN + LEN, 0, 0);
    idle(WN + LEN + 5);
    drained("R4 wake normal");
    pulse_read();
    cfg_turbo = 1'b1;
    start_conv(WT + LEN, 0, 0);
    idle(WT + LEN + 5);
    drained("R4 wake turbo");
    pulse_read();
    use_int_osc = 1'b0; cfg_turbo = 1'b0;

    // R5 restart mid-conversion
    start_conv(0, 0, 0);
    idle(10);
    check(drdy_n == 1'b1, "R5 no early ready", drdy_n, 1);
    start_conv(LEN, 0, 0);
    idle(LEN + 5);
    drained("R5 restart count");
    // R6 start clears a pending ready
    start_conv(LEN, 0, 0);
    check(drdy_n == 1'b1, "R6 start clears ready", drdy_n, 1);
    idle(LEN + 5);
    drained("R6 second conversion");
    pulse_read();

    // R10 power-down aborts
    start_conv(0, 0, 0);
    idle(10);
    pulse_pd();
    idle(LEN + 5);
    check(drdy_n && low_pwr, "R10 abort no ready", {drdy_n, low_pwr}, 2'b11);

    // R8 switch forced open
    start_conv(LEN, 0, 0);
    idle(3);
    check(sw_on == 1'b1, "R7 switch closed by start", sw_on, 1);
    cfg_psw = 1'b0;
    #1 check(sw_on == 1'b0, "R8 immediate open", sw_on, 0);
    idle(2);
    cfg_psw = 1'b1;
    idle(2);
    check(sw_on == 1'b0, "R8 stays open", sw_on, 0);
    idle(LEN);
    drained("R8 conversion");
    pulse_read();

    // R9 zero current code
    pulse_pd();
    cfg_idac = 3'd0;
    start_conv(LEN, 0, 0);
    idle(3);
    check(idac_on == 1'b0, "R9 zero code keeps current off", idac_on, 0);
    idle(LEN);
    drained("R9 conversion");
    pulse_read();

    // R11 priority
    @(negedge clk); cmd_start = 1'b1; cmd_pwrdn = 1'b1;
    @(negedge clk); cmd_start = 1'b0; cmd_pwrdn = 1'b0;
    check(low_pwr == 1'b1, "R11 power-down beats start", low_pwr, 1);
    cfg_idac = 3'd5;
    start_conv(0, 0, 0);
    idle(4);
    @(negedge clk); cmd_reset = 1'b1; cmd_start = 1'b1;
    @(negedge clk); cmd_reset = 1'b0; cmd_start = 1'b0;
    check(low_pwr && drdy_n && !sw_on && !idac_on, "R11/R1 reset wins",
          {low_pwr, drdy_n, sw_on, idac_on}, 4'b1100);
    idle(LEN + 5);
    check(drdy_n == 1'b1, "R11 no conversion after reset", drdy_n, 1);

    // R12 tick enable every other cycle
    half_tick = 1'b1;
    start_conv(2 * LEN - 1, 0, 0);
    idle(2 * LEN + 5);
    drained("R12 half-rate ticks");
    half_tick = 1'b0;

    finish_run();
  end
endmodule